// File: doc/BRIEF.md
# Chained-start router for paired DMA channels

This block lets one DMA channel start another without software. A channel can take the role of a group's source or a group's destination. Two groups can be active at once. Each channel also holds a trigger level. When the source of a group reports a completion at the level it has selected, the block raises a one-cycle start pulse on that group's destination channel. The levels are fragment, block, transaction and link-list. The transfer engines and their address paths sit outside the block. They appear here only as per-channel completion pulses coming in and per-channel start pulses going out.

Configuration arrives through a plain write port that carries one packed 32-bit flag word per channel. Only the role field and the trigger field are kept. The request-mode byte, the interrupt-type byte and all other bits are accepted and then dropped. Apart from the trigger link, every channel keeps its own settings and runs on its own. The block has no data stream, so it has no valid/ready interface. Every pin is a plain control pulse or level.

Top module: `chtrig_router`

## Requirements
- R1: After reset every channel has role "none" and trigger "none", and `start_o` is all zero. With that configuration, no completion pulse on any level or channel produces a start.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data[26:24]` as the role and `cfg_wr_data[18:16]` as the trigger of channel `cfg_wr_ch`. All other bits are ignored. The new values govern completion pulses from the cycle after the write. A completion pulse in the same cycle as the write still uses the old values.
- R3: The role codes are 0 = none, 1 = source of group 0, 2 = source of group 1, 3 = destination of group 0 and 4 = destination of group 1. The source's trigger code selects which completion input counts: 1 = fragment (`frag_done_i`), 2 = block (`blk_done_i`), 3 = transaction (`xfer_done_i`) and 4 = link-list (`list_done_i`). Pulses at the other levels are ignored.
- R4: A qualifying completion sampled at clock edge N sets `start_o` for exactly one cycle after edge N. That bit belongs to the group's destination channel, and no other bit is set.
- R5: The two groups work independently. Completions on both sources in the same cycle start both destinations in the same cycle.
- R6: No start is issued when the source has role 0 or trigger 0. No start is issued when the destination has trigger 0.
- R7: If no channel is configured as a live destination of a group, a completion on that group's source is ignored.
- R8: Role or trigger codes 5, 6 and 7 are stored and treated as "none".
- R9: When several channels hold the same source role, only the lowest-numbered one with a non-zero trigger acts as the source. When several hold the same destination role, only the lowest-numbered one with a non-zero trigger receives the start.
- R10: Completions on a destination channel, or on the source of the other group, never start that destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_ch | input | CH_W | Channel being configured |
| cfg_wr_data | input | 32 | Packed flag word (role at [26:24], trigger at [18:16]) |
| frag_done_i | input | N_CH | Per-channel fragment-complete pulses |
| blk_done_i | input | N_CH | Per-channel block-complete pulses |
| xfer_done_i | input | N_CH | Per-channel transaction-complete pulses |
| list_done_i | input | N_CH | Per-channel link-list-complete pulses |
| start_o | output | N_CH | Per-channel chained start pulses, registered |

## Verification
Faults in the stored role or trigger of a channel show up on the very next completion pulse for that channel. `start_o` then fires on the wrong channel, at the wrong level, or not at all, one cycle after the pulse. Faults in the source and destination selection appear only when several channels share a role, so the directed scenarios deliberately duplicate roles. A stuck start register is caught when the pulse width is checked one cycle later.

// File: rtl/chtrig_pkg.sv
package chtrig_pkg;
  localparam int ROLE_LSB = 24;
  localparam int TRIG_LSB = 16;
  localparam int CODE_W   = 3;
  localparam int N_GROUPS = 2;

  typedef enum logic [CODE_W-1:0] {
    ROLE_NONE = 3'd0,
    ROLE_SRC0 = 3'd1,
    ROLE_SRC1 = 3'd2,
    ROLE_DST0 = 3'd3,
    ROLE_DST1 = 3'd4
  } role_e;

  typedef enum logic [CODE_W-1:0] {
    TRIG_NONE = 3'd0,
    TRIG_FRAG = 3'd1,
    TRIG_BLK  = 3'd2,
    TRIG_XFER = 3'd3,
    TRIG_LIST = 3'd4
  } trig_e;

  // Reserved codes collapse to "none" (R8)
  function automatic role_e clean_role(input logic [CODE_W-1:0] c);
    return (c > 3'd4) ? ROLE_NONE : role_e'(c);
  endfunction

  function automatic trig_e clean_trig(input logic [CODE_W-1:0] c);
    return (c > 3'd4) ? TRIG_NONE : trig_e'(c);
  endfunction
endpackage

// File: rtl/chtrig_cfg_bank.sv
module chtrig_cfg_bank
  import chtrig_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [31:0]              wr_data,
  output logic [N_CH*CODE_W-1:0]   role_o,
  output logic [N_CH*CODE_W-1:0]   trig_o
);
  role_e role_q [N_CH];
  trig_e trig_q [N_CH];

  // Request-mode, interrupt-type and spare bits are dropped (R2)
  logic unused_fields;
  assign unused_fields = ^{wr_data[31:ROLE_LSB+CODE_W],
                           wr_data[ROLE_LSB-1:TRIG_LSB+CODE_W],
                           wr_data[TRIG_LSB-1:0]};

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        role_q[i] <= ROLE_NONE;
        trig_q[i] <= TRIG_NONE;
      end else if (wr_en && (wr_ch == CH_W'(i))) begin
        role_q[i] <= clean_role(wr_data[ROLE_LSB +: CODE_W]);
        trig_q[i] <= clean_trig(wr_data[TRIG_LSB +: CODE_W]);
      end
    end
    assign role_o[i*CODE_W +: CODE_W] = role_q[i];
    assign trig_o[i*CODE_W +: CODE_W] = trig_q[i];
  end
endmodule

// File: rtl/chtrig_group_link.sv
module chtrig_group_link
  import chtrig_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int GRP  = 0
) (
  input  logic [N_CH*CODE_W-1:0] role_i,
  input  logic [N_CH*CODE_W-1:0] trig_i,
  input  logic [N_CH-1:0]        frag_i,
  input  logic [N_CH-1:0]        blk_i,
  input  logic [N_CH-1:0]        xfer_i,
  input  logic [N_CH-1:0]        list_i,
  output logic [N_CH-1:0]        fire_o
);
  localparam logic [CODE_W-1:0] SRC_CODE = CODE_W'(1 + GRP);
  localparam logic [CODE_W-1:0] DST_CODE = CODE_W'(3 + GRP);

  logic            src_found;
  logic            src_evt;
  logic            dst_found;
  logic [N_CH-1:0] dst_sel;

  // Descending scan: the lowest-numbered match is written last (R9)
  always_comb begin
    src_found = 1'b0;
    src_evt   = 1'b0;
    dst_found = 1'b0;
    dst_sel   = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      logic [CODE_W-1:0] r;
      logic [CODE_W-1:0] t;
      r = role_i[i*CODE_W +: CODE_W];
      t = trig_i[i*CODE_W +: CODE_W];
      if (r == SRC_CODE && t != TRIG_NONE) begin
        src_found = 1'b1;
        unique case (trig_e'(t))
          TRIG_FRAG: src_evt = frag_i[i];
          TRIG_BLK:  src_evt = blk_i[i];
          TRIG_XFER: src_evt = xfer_i[i];
          TRIG_LIST: src_evt = list_i[i];
          default:   src_evt = 1'b0;
        endcase
      end
      if (r == DST_CODE && t != TRIG_NONE) begin
        dst_found  = 1'b1;
        dst_sel    = '0;
        dst_sel[i] = 1'b1;
      end
    end
    fire_o = (src_found && dst_found && src_evt) ? dst_sel : '0;
  end
endmodule

// File: rtl/chtrig_router.sv
module chtrig_router
  import chtrig_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [CH_W-1:0] cfg_wr_ch,
  input  logic [31:0]     cfg_wr_data,
  input  logic [N_CH-1:0] frag_done_i,
  input  logic [N_CH-1:0] blk_done_i,
  input  logic [N_CH-1:0] xfer_done_i,
  input  logic [N_CH-1:0] list_done_i,
  output logic [N_CH-1:0] start_o
);
  logic [N_CH*CODE_W-1:0] role_w;
  logic [N_CH*CODE_W-1:0] trig_w;
  logic [N_CH-1:0]        fire_w [N_GROUPS];
  logic [N_CH-1:0]        fire_any;

  chtrig_cfg_bank #(.N_CH(N_CH), .CH_W(CH_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_ch   (cfg_wr_ch),
    .wr_data (cfg_wr_data),
    .role_o  (role_w),
    .trig_o  (trig_w)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    chtrig_group_link #(.N_CH(N_CH), .GRP(g)) u_link (
      .role_i (role_w),
      .trig_i (trig_w),
      .frag_i (frag_done_i),
      .blk_i  (blk_done_i),
      .xfer_i (xfer_done_i),
      .list_i (list_done_i),
      .fire_o (fire_w[g])
    );
  end

  always_comb begin
    fire_any = '0;
    for (int g = 0; g < N_GROUPS; g++) fire_any = fire_any | fire_w[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_o <= '0;
    else        start_o <= fire_any;
  end
endmodule

// File: rtl/chtrig_checker.sv
module chtrig_checker
  import chtrig_pkg::*;
#(
  parameter int N_CH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CH-1:0]        start_o,
  input logic [N_CH-1:0]        frag_done_i,
  input logic [N_CH-1:0]        blk_done_i,
  input logic [N_CH-1:0]        xfer_done_i,
  input logic [N_CH-1:0]        list_done_i,
  input logic [N_CH*CODE_W-1:0] role_vec,
  input logic [N_CH*CODE_W-1:0] trig_vec
);
  logic [N_GROUPS-1:0] src_live;
  logic [N_CH-1:0]     dst_live;
  logic                any_done;

  assign any_done = |(frag_done_i | blk_done_i | xfer_done_i | list_done_i);

  always_comb begin
    src_live = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (trig_vec[i*CODE_W +: CODE_W] != 3'd0) begin
        if (role_vec[i*CODE_W +: CODE_W] == 3'd1) src_live[0] = 1'b1;
        if (role_vec[i*CODE_W +: CODE_W] == 3'd2) src_live[1] = 1'b1;
      end
    end
  end

  AST_START_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_o) |-> $past(any_done)); // R4

  AST_AT_MOST_TWO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(start_o) <= 2); // R5

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assign dst_live[i] = (trig_vec[i*CODE_W +: CODE_W] != 3'd0) &&
      ((role_vec[i*CODE_W +: CODE_W] == 3'd3 && src_live[0]) ||
       (role_vec[i*CODE_W +: CODE_W] == 3'd4 && src_live[1]));

    AST_START_AT_LIVE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[i] |-> $past(dst_live[i])); // R6

    AST_CODES_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (role_vec[i*CODE_W +: CODE_W] <= 3'd4) && (trig_vec[i*CODE_W +: CODE_W] <= 3'd4)); // R8
  end
endmodule

bind chtrig_router chtrig_checker #(.N_CH(N_CH)) u_chtrig_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_o     (start_o),
  .frag_done_i (frag_done_i),
  .blk_done_i  (blk_done_i),
  .xfer_done_i (xfer_done_i),
  .list_done_i (list_done_i),
  .role_vec    (role_w),
  .trig_vec    (trig_w)
);

// File: tb/test_chtrig_router.sv
module test_chtrig_router;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr_en = 1'b0;
  logic [W-1:0] cfg_wr_ch = '0;
  logic [31:0]  cfg_wr_data = '0;
  logic [N-1:0] frag_done_i = '0, blk_done_i = '0, xfer_done_i = '0, list_done_i = '0;
  logic [N-1:0] start_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  chtrig_router #(.N_CH(N)) i_chtrig_router (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_ch(cfg_wr_ch),
    .cfg_wr_data(cfg_wr_data), .frag_done_i(frag_done_i), .blk_done_i(blk_done_i),
    .xfer_done_i(xfer_done_i), .list_done_i(list_done_i), .start_o(start_o)
  );

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: start_o=%b expected %b", tag, act, exp);
    end
  endtask

  // Flag word with junk in every field the block must ignore (R2)
  task automatic cfg(input int ch, input int role, input int trig);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_ch   = W'(ch);
    cfg_wr_data = 32'hA8A8_5AC3;
    cfg_wr_data[26:24] = 3'(role);
    cfg_wr_data[18:16] = 3'(trig);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int c = 0; c < N; c++) cfg(c, 0, 0);
  endtask

  task automatic set_done(input int lvl, input logic [N-1:0] m);
    frag_done_i = (lvl == 1) ? m : '0;
    blk_done_i  = (lvl == 2) ? m : '0;
    xfer_done_i = (lvl == 3) ? m : '0;
    list_done_i = (lvl == 4) ? m : '0;
  endtask

  task automatic pulse_chk(input int lvl, input logic [N-1:0] chs,
                           input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    set_done(lvl, chs);
    @(negedge clk);
    check(start_o, exp, tag);
    set_done(0, '0);
    @(negedge clk);
    check(start_o, '0, {tag, " single cycle"});
  endtask

  task automatic t_reset();
    check(start_o, '0, "R1 reset value");
    for (int l = 1; l <= 4; l++) pulse_chk(l, '1, '0, "R1 unconfigured");
  endtask

  task automatic t_levels();
    clear_all();
    cfg(5, 3, 1);
    for (int sel = 1; sel <= 4; sel++) begin
      cfg(1, 1, sel);
      for (int l = 1; l <= 4; l++)
        pulse_chk(l, 8'h02, (l == sel) ? 8'h20 : 8'h00, "R3 level select / R4 timing");
    end
    cfg(1, 1, 4);
    pulse_chk(4, 8'h02, 8'h20, "R2 junk bits ignored");
    // Write and completion in the same cycle: old config applies (R2)
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_ch = 3'd1; cfg_wr_data = 32'h0;
    list_done_i = 8'h02;
    @(negedge clk);
    cfg_wr_en = 1'b0; list_done_i = '0;
    check(start_o, 8'h20, "R2 same-cycle write uses old config");
    pulse_chk(4, 8'h02, 8'h00, "R2 new config applies");
    // Back-to-back completions give back-to-back starts (R4)
    cfg(1, 1, 4);
    @(negedge clk); list_done_i = 8'h02;
    @(negedge clk); check(start_o, 8'h20, "R4 back-to-back first");
    @(negedge clk); list_done_i = '0; check(start_o, 8'h20, "R4 back-to-back second");
    @(negedge clk); check(start_o, 8'h00, "R4 back-to-back end");
  endtask

  task automatic t_groups();
    clear_all();
    cfg(1, 1, 3); cfg(5, 3, 3);
    cfg(2, 2, 3); cfg(6, 4, 3);
    pulse_chk(3, 8'h06, 8'h60, "R5 both groups together");
    pulse_chk(3, 8'h04, 8'h40, "R5 group 1 alone");
    pulse_chk(3, 8'h02, 8'h20, "R5 group 0 alone");
    pulse_chk(3, 8'h60, 8'h00, "R10 done on destinations");
  endtask

  task automatic t_disabled();
    clear_all();
    cfg(1, 1, 0); cfg(5, 3, 1);
    for (int l = 1; l <= 4; l++) pulse_chk(l, 8'h02, 8'h00, "R6 source trigger none");
    cfg(1, 1, 1); cfg(5, 3, 0);
    pulse_chk(1, 8'h02, 8'h00, "R6 destination trigger none");
    cfg(5, 3, 1); cfg(1, 0, 1);
    pulse_chk(1, 8'h02, 8'h00, "R6 source role none");
    cfg(1, 1, 1);
    pulse_chk(1, 8'h02, 8'h20, "R6 re-enabled");
  endtask

  task automatic t_no_dest();
    clear_all();
    cfg(1, 1, 2);
    pulse_chk(2, 8'h02, 8'h00, "R7 group 0 without destination");
    cfg(7, 4, 2);
    pulse_chk(2, 8'h02, 8'h00, "R10 other group destination not started");
  endtask

  task automatic t_reserved();
    clear_all();
    cfg(1, 1, 1); cfg(5, 5, 1);
    pulse_chk(1, 8'h02, 8'h00, "R8 reserved role 5");
    cfg(5, 7, 1);
    pulse_chk(1, 8'h02, 8'h00, "R8 reserved role 7");
    cfg(5, 3, 1); cfg(1, 1, 6);
    for (int l = 1; l <= 4; l++) pulse_chk(l, 8'h02, 8'h00, "R8 reserved trigger 6");
    cfg(1, 1, 1);
    pulse_chk(1, 8'h02, 8'h20, "R8 valid again");
  endtask

  task automatic t_priority();
    clear_all();
    cfg(2, 1, 1); cfg(4, 1, 1);
    cfg(3, 3, 1); cfg(6, 3, 1);
    pulse_chk(1, 8'h04, 8'h08, "R9 lowest source and lowest destination");
    pulse_chk(1, 8'h10, 8'h00, "R9 higher source ignored");
    cfg(2, 1, 0);
    pulse_chk(1, 8'h10, 8'h08, "R9 source falls through when lower disabled");
    cfg(3, 3, 0);
    pulse_chk(1, 8'h10, 8'h40, "R9 destination falls through");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_groups();
    t_disabled();
    t_no_dest();
    t_reserved();
    t_priority();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule